// File: doc/BRIEF.md
# Abortable Repeating Sequence Generator

This block is a small Moore machine that drives one serial bit. While idle it holds the line at a constant high level. A single-cycle start request moves it into a five-step bit pattern, 1, 0, 1, 1, 1, emitted one bit per clock and looped without end. A stop request, sampled on the clock edge, drops it back to idle from any step of the pattern.

Typical use is as a test-tone or marker source. A controller pulses the start input once, lets the loop run for as many repetitions as it needs, and then pulses the stop input. The pattern, its length and the idle level are elaboration-time parameters. A parameter also selects a binary step counter or a one-hot ring for the internal state.

Top module: `seqgen_abortable`

## Requirements
- R1: A synchronous active-high reset puts the block in idle, and seq reads 1 in the cycle after the reset edge.
- R2: In idle with gen and term both low, the block stays idle and seq stays 1.
- R3: When gen is 1 at an edge while idle (term low), seq shows 1, 0, 1, 1, 1 on the following five cycles, one bit per cycle, starting in the cycle right after that edge.
- R4: After the fifth bit the pattern starts again at its first bit and keeps looping with gen low.
- R5: When term is 1 at an edge, the block is idle in the next cycle whatever step it was on, and seq stays 1 from then on until gen starts it again.
- R6: If gen and term are both 1 at the same edge, term wins and the block ends up idle.
- R7: gen high while the pattern is running has no effect on the bit sequence.
- R8: Reset asserted in the middle of the pattern returns the block to idle, and seq reads 1 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| gen | input | 1 | Start request, sampled on the clock edge |
| term | input | 1 | Stop request, sampled on the clock edge, overrides gen |
| seq | output | 1 | Serial pattern output, decoded from state only |

## Verification
The embedded properties assume that gen and term are settled before each rising edge and do not change within a setup window around it. The properties put no limit on how long either input stays high, so a held or a repeated request is legal. The bench changes inputs only on the falling edge and reads seq on the next falling edge. Each sample therefore shows exactly one state transition, and the properties see clean single-edge input values.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;

   typedef enum logic {
      MODE_IDLE = 1'b0,
      MODE_RUN  = 1'b1
   } mode_e;

   // Position after the current one, wrapping at the last step.
   function automatic int unsigned next_step(input int unsigned cur, input int unsigned len);
      return (cur + 1 >= len) ? 0 : cur + 1;
   endfunction

endpackage

// File: rtl/seqgen_step_ctr.sv
module seqgen_step_ctr
   import seqgen_pkg::*;
#(
   parameter int LEN    = 5,
   parameter bit ONEHOT = 1'b0,
   localparam int POS_W = $clog2(LEN)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             gen,
   input  logic             term,
   output logic             active,
   output logic [POS_W-1:0] pos
);

   localparam logic [POS_W-1:0] LAST = POS_W'(LEN - 1);

   if (LEN < 2) begin : g_len_bad
      $error("seqgen_step_ctr: LEN must be at least 2");
   end

   if (ONEHOT) begin : g_ring
      logic [LEN-1:0] ring;

      always_ff @(posedge clk) begin
         if (rst || term) begin
            ring <= '0;
         end else if (ring == '0) begin
            if (gen) ring <= LEN'(1);
         end else begin
            ring <= {ring[LEN-2:0], ring[LEN-1]};
         end
      end

      assign active = |ring;

      always_comb begin
         pos = '0;
         for (int i = 0; i < LEN; i++) begin
            if (ring[i]) pos = POS_W'(i);
         end
      end

      ring_onehot_chk: assert property (@(posedge clk) disable iff (rst)
         $onehot0(ring));
   end else begin : g_bin
      mode_e            mode;
      logic [POS_W-1:0] step;

      always_ff @(posedge clk) begin
         if (rst || term) begin
            mode <= MODE_IDLE;
            step <= '0;
         end else if (mode == MODE_IDLE) begin
            if (gen) begin
               mode <= MODE_RUN;
               step <= '0;
            end
         end else begin
            step <= POS_W'(next_step(int'(step), LEN));
         end
      end

      assign active = (mode == MODE_RUN);
      assign pos    = step;
   end

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!active && !gen && !term) |=> !active);

   // R3
   start_chk: assert property (@(posedge clk) disable iff (rst)
      (!active && gen && !term) |=> (active && pos == '0));

   // R3
   advance_chk: assert property (@(posedge clk) disable iff (rst)
      (active && !term && pos != LAST) |=> (active && pos == $past(pos) + POS_W'(1)));

   // R4
   wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (active && !term && pos == LAST) |=> (active && pos == '0));

   // R5
   abort_chk: assert property (@(posedge clk) disable iff (rst)
      term |=> !active);

   // R6
   priority_chk: assert property (@(posedge clk) disable iff (rst)
      (gen && term) |=> !active);

   // R7
   run_gen_chk: assert property (@(posedge clk) disable iff (rst)
      (active && gen && !term) |=> active);

endmodule

// File: rtl/seqgen_out_dec.sv
module seqgen_out_dec #(
   parameter int             LEN        = 5,
   parameter logic [LEN-1:0] PATTERN    = 5'b11101,
   parameter logic           IDLE_LEVEL = 1'b1,
   localparam int            POS_W      = $clog2(LEN)
) (
   input  logic             active,
   input  logic [POS_W-1:0] pos,
   output logic             bit_out
);

   always_comb begin
      bit_out = IDLE_LEVEL;
      if (active && (int'(pos) < LEN)) bit_out = PATTERN[pos];
   end

endmodule

// File: rtl/seqgen_abortable.sv
module seqgen_abortable #(
   parameter int             LEN        = 5,
   parameter logic [LEN-1:0] PATTERN    = 5'b11101,
   parameter logic           IDLE_LEVEL = 1'b1,
   parameter bit             ONEHOT     = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic gen,
   input  logic term,
   output logic seq
);

   localparam int POS_W = $clog2(LEN);

   logic             active;
   logic [POS_W-1:0] pos;

   seqgen_step_ctr #(
      .LEN    (LEN),
      .ONEHOT (ONEHOT)
   ) u_ctr (
      .clk    (clk),
      .rst    (rst),
      .gen    (gen),
      .term   (term),
      .active (active),
      .pos    (pos)
   );

   seqgen_out_dec #(
      .LEN        (LEN),
      .PATTERN    (PATTERN),
      .IDLE_LEVEL (IDLE_LEVEL)
   ) u_dec (
      .active  (active),
      .pos     (pos),
      .bit_out (seq)
   );

   // R5
   abort_level_chk: assert property (@(posedge clk) disable iff (rst)
      term |=> (seq == IDLE_LEVEL));

   // R3
   first_bit_chk: assert property (@(posedge clk) disable iff (rst)
      (!active && gen && !term) |=> (seq == PATTERN[0]));

endmodule

// File: tb/seqgen_abortable_test.sv
module seqgen_abortable_test;

   logic clk = 1'b0;
   logic rst, gen, term;
   logic seq;
   int   checks = 0;
   int   errors = 0;
   int   cycles = 0;

   always #2.5 clk = ~clk;

   seqgen_abortable uut (
      .clk  (clk),
      .rst  (rst),
      .gen  (gen),
      .term (term),
      .seq  (seq)
   );

   // {gen, term, expected seq in the cycle after the edge}
   localparam logic [2:0] VEC [24] = '{
      3'b001, 3'b101, 3'b000, 3'b001, 3'b101, 3'b001,
      3'b001, 3'b000, 3'b011, 3'b001, 3'b001, 3'b111,
      3'b001, 3'b101, 3'b000, 3'b001, 3'b001, 3'b001,
      3'b001, 3'b000, 3'b001, 3'b011, 3'b001, 3'b001
   };

   function automatic logic pat_bit(input int j);
      return (j % 5 == 1) ? 1'b0 : 1'b1;
   endfunction

   task automatic check(input logic exp, input string req);
      checks++;
      if (seq !== exp) begin
         errors++;
         $display("FAIL %s: seq=%b expected=%b at cycle %0d", req, seq, exp, cycles);
      end
   endtask

   // Inputs set at a falling edge, seq read at the next falling edge.
   task automatic step(input logic g, input logic t, input logic exp, input string req);
      gen  = g;
      term = t;
      @(negedge clk);
      check(exp, req);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         errors++;
         $display("FAIL watchdog: run did not end, actual=%0d expected<=5000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; gen = 1'b0; term = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(1'b1, "R1 reset level");
      rst = 1'b0;

      // R2 R3 R4 R5 R6 R7 table walk
      for (int i = 0; i < 24; i++) begin
         step(VEC[i][2], VEC[i][1], VEC[i][0], "R2/R3/R4/R5/R6/R7 table");
      end

      // R4: several full repetitions without gen held
      step(1'b1, 1'b0, pat_bit(0), "R3 start");
      for (int j = 1; j < 16; j++) step(1'b0, 1'b0, pat_bit(j), "R4 repeat");
      step(1'b0, 1'b1, 1'b1, "R5 abort");

      // R5: abort at each of the five positions
      for (int k = 0; k < 5; k++) begin
         step(1'b1, 1'b0, pat_bit(0), "R3 start");
         for (int j = 1; j <= k; j++) step(1'b0, 1'b0, pat_bit(j), "R3 pattern");
         step(1'b0, 1'b1, 1'b1, "R5 abort position");
         for (int j = 0; j < 6; j++) step(1'b0, 1'b0, 1'b1, "R5 stays idle");
      end

      // R7: gen held high through the whole loop
      step(1'b1, 1'b0, pat_bit(0), "R3 start");
      for (int j = 1; j < 11; j++) step(1'b1, 1'b0, pat_bit(j), "R7 gen ignored");
      step(1'b1, 1'b1, 1'b1, "R6 term over gen");
      step(1'b0, 1'b0, 1'b1, "R6 idle after tie");

      // R8: reset in the middle of the pattern
      step(1'b1, 1'b0, pat_bit(0), "R3 start");
      step(1'b0, 1'b0, pat_bit(1), "R3 pattern");
      rst = 1'b1;
      step(1'b0, 1'b0, 1'b1, "R8 reset mid pattern");
      rst = 1'b0;
      for (int j = 0; j < 6; j++) step(1'b0, 1'b0, 1'b1, "R8 idle after reset");
      step(1'b1, 1'b0, pat_bit(0), "R8 restart");
      step(1'b0, 1'b0, pat_bit(1), "R8 restart");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule